// File: doc/BRIEF.md
# Six-Pin I/O Port with Pin-Change Wake-Up

This block is the general-purpose I/O port of a small low-power core. It holds a write-only direction register and an output data register, returns synchronized pin levels on reads, and drives per-pin output-enable and pull-up-enable signals toward the pad ring. The pads and the pull-up resistors are outside the block. Two pins have fixed exceptions: pin 3 can never drive, and pin 2 is made an input whenever the timer takes its clock from that pin.

While the core sleeps, the block watches pins 0, 1 and 3. It compares their synchronized levels against a snapshot taken at the most recent read or write of the port. When a watched input pin differs from its snapshot, the block raises a one-cycle wake pulse and sets a sticky wake flag. The flag stays set until a hard reset, so software can tell after waking why the core came out of sleep. Software must touch the port just before entering sleep so that the snapshot is current.

All register loads are single-cycle strobes with no handshake. A strobe takes effect at the clock edge where it is seen high, and the port never stalls.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset every direction bit is 1 (input), so all of `pin_oe` is 0; `pin_out` is 0, and `wake_pulse` and `wake_flag` are 0.
- R2: A clock edge with `dir_wr` high loads `dir_wdata` into the direction register (bit value 0 = output). For pins 0, 1, 4 and 5, `pin_oe[i]` is the inverse of the direction bit. The direction register cannot be read back through `dat_rdata`.
- R3: `pin_oe[3]` is always 0, whatever the direction bit says.
- R4: While `tmr_src_ext` is 1, `pin_oe[2]` is 0 regardless of the direction bit. While it is 0, `pin_oe[2]` follows the direction bit as in R2.
- R5: A clock edge with `dat_wr` high loads `dat_wdata` into the output register. `pin_out` shows that register whatever the direction setting.
- R6: `dat_rdata` is `pin_in` delayed through a two-flop synchronizer, so it shows the pin levels sampled two rising edges earlier.
- R7: `pu_en[i]` is 1 exactly when `opt_pu_n` is 0 (active low) and direction bit i is 1.
- R8: A pin takes part in wake detection only if it is pin 0, 1 or 3, its direction bit is 1, and `opt_wu_n` is 0 (active low). Changes on pins 2, 4 and 5 never wake the core.
- R9: An edge with `dat_wr` or `dat_rd` high copies the current synchronized pin levels into the wake snapshot. Wake detection compares against this snapshot. The snapshot is 0 after reset.
- R10: With `sleep` high, the first cycle in which any enabled pin differs from its snapshot produces a `wake_pulse` exactly one cycle long at the following edge. No further pulse occurs until the mismatch or `sleep` has gone away and come back.
- R11: `wake_flag` becomes 1 at the same edge as `wake_pulse` and stays 1 until `rst_n` is asserted.
- R12: With `sleep` low, no pin activity produces `wake_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous hard reset (clears the wake flag) |
| dir_wr | input | 1 | Load strobe for the direction register |
| dir_wdata | input | 6 | Direction value, 1 = input, 0 = output |
| dat_wr | input | 1 | Load strobe for the output register; also refreshes the snapshot |
| dat_wdata | input | 6 | Output register value |
| dat_rd | input | 1 | Port read strobe; refreshes the snapshot |
| dat_rdata | output | 6 | Synchronized pin levels |
| opt_pu_n | input | 1 | Global pull-up enable, active low |
| opt_wu_n | input | 1 | Global wake-on-change enable, active low |
| tmr_src_ext | input | 1 | Timer clocks from pin 2; forces pin 2 to input |
| sleep | input | 1 | Core is in sleep mode |
| pin_in | input | 6 | Pad input levels |
| pin_out | output | 6 | Pad output levels |
| pin_oe | output | 6 | Pad output enables |
| pu_en | output | 6 | Pull-up enables toward the pads |
| wake_pulse | output | 1 | One-cycle wake request |
| wake_flag | output | 1 | Sticky wake-by-pin-change indicator |

## Verification
The bench targets the pin exceptions. A design that let pin 3 drive, or that ignored the timer-source override on pin 2, would show an enabled output where the pad must stay high-impedance. It toggles pins 2, 4 and 5 and an output-configured pin 0 during sleep. A design that used the wrong wake mask, or that let the global options override the direction bits, would pulse at one of those points. It also moves the snapshot with a read just before a change, and holds a mismatch across several cycles. A design that compared against a stale value, or that re-pulsed every cycle, would fire early, fire late or fire repeatedly. Finally it checks that the flag survives the end of sleep and later port accesses.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int PORT_W      = 6;
  localparam int SYNC_STAGES = 2;
  localparam int TMR_PIN     = 2;
  // pins that may never drive
  localparam logic [PORT_W-1:0] IN_ONLY_MASK = 6'b00_1000;
  // pins watched during sleep
  localparam logic [PORT_W-1:0] WAKE_MASK    = 6'b00_1011;
  // direction value after reset: all inputs
  localparam logic [PORT_W-1:0] DIR_RESET    = {PORT_W{1'b1}};
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_wake_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_wr,
  input  logic [W-1:0] dir_wdata,
  input  logic         dat_wr,
  input  logic [W-1:0] dat_wdata,
  input  logic         opt_pu_n,
  input  logic         tmr_src_ext,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] pu
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RESET[W-1:0];
      out_q <= '0;
    end else begin
      if (dir_wr) dir_q <= dir_wdata;
      if (dat_wr) out_q <= dat_wdata;
    end
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic forced_in;
      if (i == TMR_PIN) begin : g_tmr
        assign forced_in = IN_ONLY_MASK[i] | tmr_src_ext;
      end else begin : g_plain
        assign forced_in = IN_ONLY_MASK[i];
      end
      assign oe[i] = ~dir_q[i] & ~forced_in;
      assign pu[i] = ~opt_pu_n & dir_q[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det
  import gpio_wake_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_sync,
  input  logic [W-1:0] dir_q,
  input  logic         port_access,
  input  logic         opt_wu_n,
  input  logic         sleep,
  output logic         pulse,
  output logic         flag
);
  logic [W-1:0] snap_q;
  logic [W-1:0] watch;
  logic         mismatch;
  logic         hit_q;

  assign watch    = WAKE_MASK[W-1:0] & dir_q & {W{~opt_wu_n}};
  assign mismatch = sleep & (|((pins_sync ^ snap_q) & watch));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      hit_q  <= 1'b0;
      pulse  <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (port_access) snap_q <= pins_sync;
      hit_q <= mismatch;
      pulse <= mismatch & ~hit_q;
      if (mismatch & ~hit_q) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gpio_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_wr,
  input  logic [PORT_W-1:0] dir_wdata,
  input  logic              dat_wr,
  input  logic [PORT_W-1:0] dat_wdata,
  input  logic              dat_rd,
  output logic [PORT_W-1:0] dat_rdata,
  input  logic              opt_pu_n,
  input  logic              opt_wu_n,
  input  logic              tmr_src_ext,
  input  logic              sleep,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pu_en,
  output logic              wake_pulse,
  output logic              wake_flag
);
  logic [PORT_W-1:0] pins_s;
  logic [PORT_W-1:0] dir_q;

  gpio_pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pins_s)
  );

  gpio_ctrl_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .dir_wr(dir_wr), .dir_wdata(dir_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .opt_pu_n(opt_pu_n), .tmr_src_ext(tmr_src_ext),
    .dir_q(dir_q), .out_q(pin_out), .oe(pin_oe), .pu(pu_en)
  );

  gpio_wake_det #(.W(PORT_W)) u_wake (
    .clk(clk), .rst_n(rst_n),
    .pins_sync(pins_s), .dir_q(dir_q),
    .port_access(dat_wr | dat_rd),
    .opt_wu_n(opt_wu_n), .sleep(sleep),
    .pulse(wake_pulse), .flag(wake_flag)
  );

  assign dat_rdata = pins_s;
endmodule

// File: rtl/gpio_wake_port_chk.sv
module gpio_wake_port_chk
  import gpio_wake_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              dir_wr,
  input logic [PORT_W-1:0] dir_wdata,
  input logic              dat_wr,
  input logic [PORT_W-1:0] dat_wdata,
  input logic              dat_rd,
  input logic [PORT_W-1:0] dat_rdata,
  input logic              opt_pu_n,
  input logic              opt_wu_n,
  input logic              tmr_src_ext,
  input logic              sleep,
  input logic [PORT_W-1:0] pin_in,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pu_en,
  input logic              wake_pulse,
  input logic              wake_flag
);
  // R3
  in_only_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe[3]);

  // R4
  tmr_pin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_src_ext |-> !pin_oe[2]);

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (pin_oe[0] == ~$past(dir_wdata[0])));

  // R5
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> (pin_out == $past(dat_wdata)));

  // R7
  pullup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opt_pu_n |-> (pu_en == '0));

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R11
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> wake_flag);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_flag |=> wake_flag);

  // R12
  pulse_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(sleep));
endmodule

bind gpio_wake_port gpio_wake_port_chk u_chk (.*);

// File: tb/sim_gpio_wake_port.sv
`timescale 1ns/1ps
module sim_gpio_wake_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [5:0] dir_wdata = '0, dat_wdata = '0, pin_in = '0;
  logic       opt_pu_n = 1'b1, opt_wu_n = 1'b1, tmr_src_ext = 1'b0, sleep = 1'b0;
  logic [5:0] dat_rdata, pin_out, pin_oe, pu_en;
  logic       wake_pulse, wake_flag;
  int total = 0, bad = 0;
  int pulses = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_wake_port u0 (.*);

  // behavioural reference
  logic [5:0] m_dir, m_out, m_s1, m_s2, m_snap;
  logic       m_hit, m_pulse, m_flag;

  function automatic logic m_cond();
    logic [5:0] en = m_dir & 6'b001011 & {6{~opt_wu_n}};
    return sleep && (((m_s2 ^ m_snap) & en) != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 6'h3F; m_out = 0; m_s1 = 0; m_s2 = 0; m_snap = 0;
      m_hit = 0; m_pulse = 0; m_flag = 0;
    end else begin
      logic c;
      c = m_cond();
      m_pulse = c && !m_hit;
      if (m_pulse) m_flag = 1;
      m_hit = c;
      if (dat_wr || dat_rd) m_snap = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (dir_wr) m_dir = dir_wdata;
      if (dat_wr) m_out = dat_wdata;
    end
  end

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [5:0] eoe;
      for (int i = 0; i < 6; i++)
        eoe[i] = !m_dir[i] && i != 3 && !(i == 2 && tmr_src_ext);
      chk("pin_oe R2 R3 R4", pin_oe, eoe);
      chk("pin_out R5", pin_out, m_out);
      chk("dat_rdata R6", dat_rdata, m_s2);
      chk("pu_en R7", pu_en, m_dir & {6{~opt_pu_n}});
      chk("wake_pulse R8 R9 R10 R12", {5'b0, wake_pulse}, {5'b0, m_pulse});
      chk("wake_flag R11", {5'b0, wake_flag}, {5'b0, m_flag});
      if (wake_pulse) pulses++;
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  task automatic wr_dir(input logic [5:0] v);
    dir_wr = 1; dir_wdata = v; cyc(1); dir_wr = 0;
  endtask

  task automatic wr_dat(input logic [5:0] v);
    dat_wr = 1; dat_wdata = v; cyc(1); dat_wr = 0;
  endtask

  task automatic rd_port();
    dat_rd = 1; cyc(1); dat_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    cyc(1);
    do_reset();
    // R1 reset state
    chk("reset pin_oe R1", pin_oe, 6'h00);
    chk("reset flag R1", {5'b0, wake_flag}, 6'h00);

    // R2 R3 R5: all outputs requested, pin 3 stays input
    wr_dir(6'h00);
    wr_dat(6'h2A);
    cyc(2);
    chk("pin3 never drives R3", {5'b0, pin_oe[3]}, 6'h00);
    // R4 timer source forces pin 2 input
    tmr_src_ext = 1; cyc(2);
    chk("pin2 forced R4", {5'b0, pin_oe[2]}, 6'h00);
    tmr_src_ext = 0; cyc(2);
    // R6 input patterns
    pin_in = 6'h15; cyc(3);
    pin_in = 6'h2A; cyc(1); pin_in = 6'h3F; cyc(3);
    // R7 pull-ups
    opt_pu_n = 0; wr_dir(6'h33); cyc(2);
    chk("pullup dir R7", pu_en, 6'h33);
    opt_pu_n = 1; cyc(2);

    // R8 R9 R10 wake path
    wr_dir(6'h3F); opt_wu_n = 0; pin_in = 6'h00; cyc(3);
    rd_port(); cyc(1);
    sleep = 1; cyc(2);
    p0 = pulses;
    pin_in = 6'h34; cyc(6);                // pins 2,4,5 only
    chk("no wake on masked pins R8", pulses - p0, 0);
    pin_in = 6'h36; cyc(8);                // pin 1 changes, held
    chk("single wake pulse R10", pulses - p0, 1);
    sleep = 0; cyc(2);
    rd_port(); wr_dat(6'h01); cyc(3);
    chk("flag sticky R11", {5'b0, wake_flag}, 6'h01);

    // R12 no wake while awake
    do_reset(); opt_wu_n = 0; pin_in = 6'h00; cyc(3); rd_port();
    p0 = pulses;
    pin_in = 6'h0B; cyc(6);
    chk("no wake awake R12", pulses - p0, 0);

    // R8 output pin excluded; R9 snapshot refreshed before sleep
    rd_port(); wr_dir(6'h3E); cyc(2); sleep = 1;
    pin_in = 6'h0A; cyc(6);                // pin 0 output: ignored
    chk("output pin no wake R8", pulses - p0, 0);
    pin_in = 6'h08; cyc(6);                // pin 1 changes
    chk("wake vs snapshot R9", pulses - p0, 1);
    opt_wu_n = 1; sleep = 0; cyc(2);

    // R8 global option disables wake
    do_reset(); rd_port(); sleep = 1; pin_in = 6'h01; cyc(6);
    chk("opt off no wake R8", {5'b0, wake_flag}, 6'h00);
    sleep = 0; cyc(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule